// File: doc/BRIEF.md
# Serial Converter Command-Frame Front End

This block is the device-side digital front end of a four-channel, 10-bit serial analog-to-digital converter operating with an externally supplied serial clock. It watches an active-low chip select, the serial clock and a serial data input. It finds a start bit by scanning for the first logic 1 and gathers an 8-bit command byte. On the serial-clock falling edge after the last command bit, it launches a conversion by latching a parallel 10-bit sample input, which stands in for the analog quantiser. It then returns the result serially, most significant bit first.

All three serial pins are assumed to be synchronous to the fast core clock `clk`, which oversamples them. Serial-clock edges are detected internally. While the tail of a result is still leaving, a new start bit may already arrive, so command frames can follow each other every 15 serial clocks. Raising chip select abandons any frame or result in progress.

Top module: `serial_adc_frontend`

## Requirements
- R1: A falling chip select does not begin a frame or a conversion by itself, and zeros on the data input never begin one. The strobe stays high and the result output stays 0 until a start bit and seven further command bits have been sampled.
- R2: While chip select is low and no frame or early result is pending, the first 1 sampled on a serial-clock rising edge is the start bit, which is command bit 7. The next seven rising edges fill bits 6..0. After the conversion starts, command bits 6..4 appear on `chan_o`.
- R3: The conversion starts on the serial-clock falling edge that follows the sampling of command bit 0. On that edge `sample_i` is latched, `dout_o` drives 0, and the strobe drops low until the next falling edge.
- R4: Falling edges 1 to 10 after the conversion start drive result bits 9 down to 0 on `dout_o`. Every later falling edge drives 0. `dout_o` changes on no other serial-clock edge.
- R5: After a conversion, a 1 on the data input is taken as a new start bit only on rising edges after the falling edge that put result bit 3 on `dout_o`. A 1 sampled earlier is ignored. Back-to-back frames of 15 serial clocks therefore work.
- R6: Chip select high abandons any command or result in progress. The strobe returns high, `dout_o` reads 0, and after chip select goes low again the next sampled 1 starts a new frame.
- R7: Sixteen serial clocks with zeros on the data input and chip select low leave the block ready, so that a following command byte converts normally.
- R8: After reset, the strobe is high, `chan_o` is 0, and `dout_o` is 0 until the first conversion.
- R9: `dout_oe_o` is low whenever chip select is high and high whenever it is low.
- R10: Frames of 16 serial clocks (8 command clocks, 8 idle clocks) repeat with correct results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial command data input |
| sample_i | input | DATA_W | Parallel sample latched when a conversion starts |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable for `dout_o` |
| ready_o | output | 1 | Strobe: low for the serial clock after conversion start |
| chan_o | output | 3 | Channel field of the last converted command |

## Verification
The hardest condition to reach from the ports is a 1 on the data input exactly one serial clock before the overlap window opens, while an earlier result is still leaving. Reaching the abort path at every frame position is equally hard. Directed frames place a 1 at serial clock 15, then at serial clock 16, of a running frame, and raise chip select both in mid-command and in mid-result. A long seeded random run then mixes dense and sparse ones on the data input with rare chip-select pulses. A serial-clock-level reference model in the bench predicts every output bit.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_CMD  = 2'd1,
    RX_WAIT = 2'd2
  } rx_state_e;

  // channel field position inside the command byte
  localparam int CHAN_W   = 3;
  localparam int CHAN_LSB = 4;
endpackage

// File: rtl/adc_fe_edge.sv
module adc_fe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = !cs_n &&  sclk && !sclk_q;
  assign fall = !cs_n && !sclk &&  sclk_q;
endmodule

// File: rtl/adc_fe_cmd_rx.sv
module adc_fe_cmd_rx
  import adc_fe_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              din,
  input  logic              rise,
  input  logic              fall,
  input  logic              scan_ok,
  output logic              conv_start,
  output logic [CHAN_W-1:0] chan
);
  localparam int CNT_W = $clog2(CTRL_W);

  rx_state_e          state_q, state_d;
  logic [CTRL_W-1:0]  creg_q, creg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CHAN_W-1:0]  chan_q, chan_d;

  always_comb begin
    state_d    = state_q;
    creg_d     = creg_q;
    cnt_d      = cnt_q;
    chan_d     = chan_q;
    conv_start = 1'b0;
    if (cs_n) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        RX_IDLE: if (rise && din && scan_ok) begin
          state_d = RX_CMD;
          creg_d  = {{(CTRL_W-1){1'b0}}, 1'b1};
          cnt_d   = CNT_W'(1);
        end
        RX_CMD: if (rise) begin
          creg_d = {creg_q[CTRL_W-2:0], din};
          cnt_d  = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(CTRL_W-1)) state_d = RX_WAIT;
        end
        RX_WAIT: if (fall) begin
          conv_start = 1'b1;
          state_d    = RX_IDLE;
          chan_d     = creg_q[CHAN_LSB +: CHAN_W];
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      creg_q  <= '0;
      cnt_q   <= '0;
      chan_q  <= '0;
    end else begin
      state_q <= state_d;
      creg_q  <= creg_d;
      cnt_q   <= cnt_d;
      if (conv_start) chan_q <= chan_d;
    end
  end

  assign chan = chan_q;
endmodule

// File: rtl/adc_fe_shifter.sv
module adc_fe_shifter #(
  parameter int DATA_W  = 10,
  parameter int OVL_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              fall,
  input  logic              conv_start,
  input  logic [DATA_W-1:0] sample,
  output logic              dout,
  output logic              ready,
  output logic              scan_ok
);
  localparam int FCNT_MAX = DATA_W + 1;
  localparam int CNT_W    = $clog2(FCNT_MAX + 1);
  localparam int OVL_CNT  = DATA_W - OVL_BIT;

  logic [CNT_W-1:0]  fcnt_q, fcnt_d;
  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic              dout_q, dout_d;
  logic              sat, upd;

  assign sat = (fcnt_q == CNT_W'(FCNT_MAX));
  assign upd = cs_n || conv_start || (fall && !sat);

  always_comb begin
    fcnt_d = fcnt_q;
    sreg_d = sreg_q;
    dout_d = dout_q;
    if (cs_n) begin
      fcnt_d = CNT_W'(FCNT_MAX);
      sreg_d = '0;
      dout_d = 1'b0;
    end else if (conv_start) begin
      fcnt_d = '0;
      sreg_d = sample;
      dout_d = 1'b0;
    end else if (fall && !sat) begin
      fcnt_d = fcnt_q + CNT_W'(1);
      dout_d = sreg_q[DATA_W-1];
      sreg_d = {sreg_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= CNT_W'(FCNT_MAX);
      sreg_q <= '0;
      dout_q <= 1'b0;
    end else if (upd) begin
      fcnt_q <= fcnt_d;
      sreg_q <= sreg_d;
      dout_q <= dout_d;
    end
  end

  assign dout    = dout_q;
  assign ready   = (fcnt_q != '0);
  assign scan_ok = (fcnt_q >= CNT_W'(OVL_CNT));
endmodule

// File: rtl/serial_adc_frontend.sv
module serial_adc_frontend
  import adc_fe_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int CTRL_W  = 8,
  parameter int OVL_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              ready_o,
  output logic [CHAN_W-1:0] chan_o
);
  logic [1:0] rst_pipe;
  logic       rst_n_sync;
  logic       sclk_rise, sclk_fall, conv_start, scan_ok;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  adc_fe_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n_sync),
    .cs_n (cs_n_i),
    .sclk (sclk_i),
    .rise (sclk_rise),
    .fall (sclk_fall)
  );

  adc_fe_cmd_rx #(.CTRL_W(CTRL_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cs_n      (cs_n_i),
    .din       (din_i),
    .rise      (sclk_rise),
    .fall      (sclk_fall),
    .scan_ok   (scan_ok),
    .conv_start(conv_start),
    .chan      (chan_o)
  );

  adc_fe_shifter #(.DATA_W(DATA_W), .OVL_BIT(OVL_BIT)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cs_n      (cs_n_i),
    .fall      (sclk_fall),
    .conv_start(conv_start),
    .sample    (sample_i),
    .dout      (dout_o),
    .ready     (ready_o),
    .scan_ok   (scan_ok)
  );

  assign dout_oe_o = !cs_n_i;
endmodule

// File: rtl/serial_adc_frontend_chk.sv
module serial_adc_frontend_chk (
  input logic clk,
  input logic rst_n_sync,
  input logic cs_n_i,
  input logic dout_o,
  input logic ready_o,
  input logic conv_start,
  input logic sclk_fall
);
  AST_NO_START_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cs_n_i |-> !conv_start); // R1
  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n_sync)
    conv_start |-> sclk_fall); // R3
  AST_STROBE_LOW_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n_sync)
    conv_start |=> !ready_o); // R3
  AST_STROBE_DROP_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(ready_o) |-> $past(conv_start)); // R3
  AST_DOUT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!sclk_fall && !cs_n_i) |=> $stable(dout_o)); // R4
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cs_n_i |=> (ready_o && !dout_o)); // R6
endmodule

bind serial_adc_frontend serial_adc_frontend_chk u_chk (
  .clk       (clk),
  .rst_n_sync(rst_n_sync),
  .cs_n_i    (cs_n_i),
  .dout_o    (dout_o),
  .ready_o   (ready_o),
  .conv_start(conv_start),
  .sclk_fall (sclk_fall)
);

// File: tb/tb_serial_adc_frontend.sv
module tb_serial_adc_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4 * CLK_PERIOD;
  localparam int DW         = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n_i = 1'b1;
  logic          sclk_i = 1'b0;
  logic          din_i = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic          dout_o, dout_oe_o, ready_o;
  logic [2:0]    chan_o;

  int n_chk = 0;
  int n_bad = 0;

  // serial-clock-level reference model
  int            m_state;   // 0 idle, 1 command, 2 waiting for fall
  int            m_cnt;
  int            m_fcnt;
  logic [7:0]    m_creg;
  logic [DW-1:0] m_data;
  logic          m_dout;
  logic [2:0]    m_chan;
  int            m_convs;

  serial_adc_frontend dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sclk_i(sclk_i), .din_i(din_i),
    .sample_i(sample_i), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
    .ready_o(ready_o), .chan_o(chan_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_abort();
    m_state = 0; m_cnt = 0; m_fcnt = DW + 1; m_data = '0; m_dout = 1'b0;
  endtask

  function automatic string out_tag();
    if (m_convs == 0)        return "R8";
    if (m_fcnt == 0)         return "R3";
    return "R4";
  endfunction

  // one serial clock with chip select low
  task automatic tick(input logic d);
    din_i    = d;
    sample_i = DW'($urandom);
    chk(out_tag(), dout_o, m_dout);
    chk("R3 strobe", ready_o, (m_fcnt != 0));
    chk("R2 chan", chan_o, m_chan);
    chk("R9 oe", dout_oe_o, 1);
    // rising edge
    if (m_state == 0) begin
      if (d && m_fcnt >= DW - 3) begin m_state = 1; m_creg = 8'd1; m_cnt = 1; end
    end else if (m_state == 1) begin
      m_creg = {m_creg[6:0], d};
      m_cnt++;
      if (m_cnt == 8) m_state = 2;
    end
    sclk_i = 1'b1;
    #(HALF);
    // falling edge
    if (m_state == 2) begin
      m_state = 0; m_data = sample_i; m_chan = m_creg[6:4];
      m_fcnt = 0; m_dout = 1'b0; m_convs++;
    end else if (m_fcnt < DW + 1) begin
      m_dout = (m_fcnt < DW) ? m_data[DW-1-m_fcnt] : 1'b0;
      m_fcnt++;
    end
    sclk_i = 1'b0;
    #(HALF);
  endtask

  task automatic set_cs(input logic v);
    cs_n_i = v;
    if (v) model_abort();
    #(HALF);
    if (v) begin
      chk("R9 oe off", dout_oe_o, 0);
      chk("R6 strobe", ready_o, 1);
      chk("R6 dout", dout_o, 0);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) tick(b[i]);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_chan = '0; m_convs = 0; model_abort();
    #(3 * CLK_PERIOD);
    @(negedge clk);
    rst_n = 1'b1;
    #(4 * CLK_PERIOD);
    // R8 reset state
    chk("R8 strobe", ready_o, 1);
    chk("R8 dout", dout_o, 0);
    chk("R8 chan", chan_o, 0);
    chk("R9 oe reset", dout_oe_o, 0);

    // R1: chip select falls, zeros only
    set_cs(1'b0);
    zeros(6);
    chk("R1 no conversion", ready_o, 1);
    chk("R1 count", m_convs, 0);

    // R5: back-to-back 15-clock frames
    send_byte(8'b1_101_0_1_11); zeros(7);
    send_byte(8'b1_011_1_0_01); zeros(7);
    send_byte(8'b1_110_0_0_11); zeros(7);
    chk("R2 chan after frames", chan_o, 3'b110);
    chk("R5 conversions", m_convs, 3);
    zeros(12);

    // R5: a 1 on serial clock 15 is too early and is ignored
    send_byte(8'b1_010_0_1_11); zeros(6); tick(1'b1);
    zeros(20);
    chk("R5 early one ignored", m_convs, 4);
    chk("R5 strobe", ready_o, 1);

    // R10: 16-clock frames
    for (int f = 0; f < 3; f++) begin
      send_byte({1'b1, 3'(f + 1), 4'b1011}); zeros(8);
    end
    chk("R10 chan", chan_o, 3);
    zeros(8);

    // R6: abort in mid-result, then a new frame
    send_byte(8'b1_111_0_1_11); zeros(4);
    set_cs(1'b1); set_cs(1'b0);
    send_byte(8'b1_001_0_1_11); zeros(14);
    chk("R6 new frame chan", chan_o, 1);

    // R6/R7: abort in mid-command, then sixteen zeros, then a frame
    tick(1'b1); tick(1'b0); tick(1'b1);
    set_cs(1'b1); set_cs(1'b0);
    zeros(16);
    chk("R7 ready after zeros", ready_o, 1);
    send_byte(8'b1_100_1_1_11); zeros(14);
    chk("R7 frame after zeros", chan_o, 4);

    // random stimulus
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 199);
      if (r == 0) begin
        set_cs(1'b1); set_cs(1'b0);
      end else begin
        tick((i % 400) < 200 ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 1) == 1));
      end
    end
    set_cs(1'b1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule